// File: doc/BRIEF.md
# Parallel Port Extended Register Window

This block implements the extended-capabilities register window of a parallel port, the group of eight byte locations that sits at a fixed distance above the port's base address. A byte-wide I/O bus reaches it through the low three address bits. The window holds four things: the extended control register, which carries a 3-bit chip mode, three stored control bits and a 2-bit FIFO status code; a configuration B scratch register; a plain data register; and a small test FIFO.

Offset 0 is shared. When the chip mode is FIFO test, writes to offset 0 push into the test FIFO and reads pop from it. In every other mode, offset 0 is a plain read/write register. Software selects the mode by writing the extended control register. Any write that changes the mode field empties the FIFO. Offset 3 returns a constant capability byte that reports an 8-bit FIFO word width. Reads are registered and return one cycle after the request, marked by a one-cycle valid pulse.

Top module: `ecpx_window`

## Requirements
- R1: After reset, offset 2 reads 0x01 (mode 0, control bits 0, FIFO empty), and offsets 0 and 1 both read 0x00.
- R2: A write to offset 2 stores bits 7:5 as the mode and bits 4:2 as control bits; bits 1:0 of the written value have no effect and always read back as the live FIFO status.
- R3: Offset 2 bits 1:0 encode the FIFO state as 2'b01 when empty, 2'b10 when it holds FIFO_DEPTH bytes, and 2'b00 when partly filled; 2'b11 never appears.
- R4: In mode 6 (FIFO test), a write to offset 0 pushes a byte and a read from offset 0 pops the oldest byte, in first-in first-out order across pointer wrap.
- R5: A push while the FIFO is full is dropped; the stored bytes and the status are unchanged.
- R6: A pop while the FIFO is empty returns 0xFF and leaves the FIFO state unchanged.
- R7: A write to offset 2 whose bits 7:5 differ from the current mode empties the FIFO; a write with the same mode leaves the FIFO contents intact.
- R8: In any mode other than 6, offset 0 reads back the last byte written to it there. FIFO-test pushes do not alter this register, and plain offset 0 accesses do not touch the FIFO.
- R9: Offset 1 reads back the last byte written to it.
- R10: Offset 3 reads the constant 0x10 (width field in bits 6:4 equal to 1, meaning 8-bit). Offsets 4 to 7 read 0xFF, and writes to them have no effect.
- R11: A read request in cycle N returns its data in cycle N+1 with `bus_rvalid` high for exactly that cycle; `bus_rvalid` is low in any cycle not preceded by a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
All internal state can be seen from the bus within one read. A wrong FIFO occupancy count shows up in the status bits of the very next read of offset 2, and a wrong read pointer shows up as out-of-order or 0xFF data on the next pop. The bench therefore follows each FIFO action with a status or data read. A missed or spurious flush appears as stale or missing bytes on the first pop after a mode write. A leak between the plain data register and the FIFO appears as soon as the mode is switched back and offset 0 is read.

// File: rtl/ecpx_pkg.sv
package ecpx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [2:0] {
    MODE_COMPAT   = 3'd0,
    MODE_BYTE     = 3'd1,
    MODE_PPFIFO   = 3'd2,
    MODE_ECPFIFO  = 3'd3,
    MODE_EPP      = 3'd4,
    MODE_RSVD     = 3'd5,
    MODE_FIFOTEST = 3'd6,
    MODE_CONFIG   = 3'd7
  } ecp_mode_e;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CFGB = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_ECR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CFGA = 3'd3;

  localparam logic [1:0] ST_SOME  = 2'b00;
  localparam logic [1:0] ST_EMPTY = 2'b01;
  localparam logic [1:0] ST_FULL  = 2'b10;

  localparam logic [2:0] WIDTH_CODE_8 = 3'd1;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/ecpx_rst_sync.sv
module ecpx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ecpx_test_fifo.sv
module ecpx_test_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  assert_full_push_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wr_ptr_q)));
  assert_empty_pop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (empty && $stable(rd_ptr_q)));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/ecpx_ctrl_regs.sv
module ecpx_ctrl_regs
  import ecpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              fifo_full,
  output ecp_mode_e         mode,
  output logic [2:0]        ctl_bits,
  output logic [BYTE_W-1:0] cfgb,
  output logic [BYTE_W-1:0] data_reg,
  output logic              flush,
  output logic              push
);
  ecp_mode_e         mode_q, mode_d;
  logic [2:0]        ctl_q, ctl_d;
  logic [BYTE_W-1:0] cfgb_q, cfgb_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              ecr_we, cfgb_we, ofs0_we, test_mode;

  assign test_mode = (mode_q == MODE_FIFOTEST);
  assign ecr_we    = wr && (addr == OFS_ECR);
  assign cfgb_we   = wr && (addr == OFS_CFGB);
  assign ofs0_we   = wr && (addr == OFS_DATA);

  always_comb begin
    mode_d = mode_q;
    ctl_d  = ctl_q;
    cfgb_d = cfgb_q;
    data_d = data_q;
    if (ecr_we) begin
      mode_d = ecp_mode_e'(wdata[7:5]);
      ctl_d  = wdata[4:2];
    end
    if (cfgb_we) cfgb_d = wdata;
    if (ofs0_we && !test_mode) data_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_COMPAT;
      ctl_q  <= '0;
      cfgb_q <= '0;
      data_q <= '0;
    end else begin
      mode_q <= mode_d;
      ctl_q  <= ctl_d;
      cfgb_q <= cfgb_d;
      data_q <= data_d;
    end
  end

  assign flush    = ecr_we && (wdata[7:5] != mode_q);
  assign push     = ofs0_we && test_mode && !fifo_full;
  assign mode     = mode_q;
  assign ctl_bits = ctl_q;
  assign cfgb     = cfgb_q;
  assign data_reg = data_q;

  assert_data_kept_in_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs0_we && test_mode) |=> $stable(data_q));
  assert_mode_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_we |=> (mode_q == $past(wdata[7:5])));
endmodule

// File: rtl/ecpx_read_port.sv
module ecpx_read_port
  import ecpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  ecp_mode_e         mode,
  input  logic [2:0]        ctl_bits,
  input  logic [BYTE_W-1:0] cfgb,
  input  logic [BYTE_W-1:0] data_reg,
  input  logic [BYTE_W-1:0] fifo_head,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              pop,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid
);
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic [1:0]        status;
  logic              test_mode;

  assign test_mode = (mode == MODE_FIFOTEST);
  assign status    = fifo_empty ? ST_EMPTY : (fifo_full ? ST_FULL : ST_SOME);
  assign pop       = rd && (addr == OFS_DATA) && test_mode && !fifo_empty;

  always_comb begin
    case (addr)
      OFS_DATA: sel_byte = test_mode ? (fifo_empty ? IDLE_BYTE : fifo_head) : data_reg;
      OFS_CFGB: sel_byte = cfgb;
      OFS_ECR:  sel_byte = {mode, ctl_bits, status};
      OFS_CFGA: sel_byte = {1'b0, WIDTH_CODE_8, 4'b0000};
      default:  sel_byte = IDLE_BYTE;
    endcase
    rdata_d = rd ? sel_byte : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  assert_status_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

// File: rtl/ecpx_window.sv
module ecpx_window
  import ecpx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid
);
  logic              rst_sync_n;
  ecp_mode_e         mode;
  logic [2:0]        ctl_bits;
  logic [BYTE_W-1:0] cfgb, data_reg, fifo_head;
  logic              flush, push, pop, fifo_empty, fifo_full;

  ecpx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ecpx_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .fifo_full (fifo_full),
    .mode      (mode),
    .ctl_bits  (ctl_bits),
    .cfgb      (cfgb),
    .data_reg  (data_reg),
    .flush     (flush),
    .push      (push)
  );

  ecpx_test_fifo #(
    .DATA_W (BYTE_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .wdata (bus_wdata),
    .head  (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  ecpx_read_port u_rd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd         (bus_rd),
    .addr       (bus_addr),
    .mode       (mode),
    .ctl_bits   (ctl_bits),
    .cfgb       (cfgb),
    .data_reg   (data_reg),
    .fifo_head  (fifo_head),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .pop        (pop),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );

  assert_flush_not_push_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(flush && push));
endmodule

// File: tb/test_ecpx_window.sv
module test_ecpx_window;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  ecpx_window i_ecpx_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: compare each returned byte with the expected queue (R11 timing)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: rvalid without request, actual %02h expected none", bus_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_byte(3'd2, 8'h01, "R1 ecr reset");
    rd_byte(3'd1, 8'h00, "R1 cfgb reset");
    rd_byte(3'd0, 8'h00, "R1 data reset");

    rd_byte(3'd3, 8'h10, "R10 cfga width");
    wr_byte(3'd5, 8'h55);
    rd_byte(3'd5, 8'hFF, "R10 ofs5");
    rd_byte(3'd4, 8'hFF, "R10 ofs4");

    wr_byte(3'd1, 8'hA5);
    rd_byte(3'd1, 8'hA5, "R9 cfgb a5");
    wr_byte(3'd1, 8'h3C);
    rd_byte(3'd1, 8'h3C, "R9 cfgb 3c");

    wr_byte(3'd0, 8'h9A);
    rd_byte(3'd0, 8'h9A, "R8 data compat");
    rd_byte(3'd2, 8'h01, "R8 fifo untouched");

    wr_byte(3'd2, 8'h1F);
    rd_byte(3'd2, 8'h1D, "R2 ecr ctl bits, status read-only");

    wr_byte(3'd2, 8'hC0);
    rd_byte(3'd2, 8'hC1, "R7 enter test mode empty");
    wr_byte(3'd0, 8'h11);
    rd_byte(3'd2, 8'hC0, "R3 some data");
    wr_byte(3'd0, 8'h22);
    rd_byte(3'd2, 8'hC2, "R3 full");
    wr_byte(3'd0, 8'h33);
    rd_byte(3'd2, 8'hC2, "R5 still full");
    rd_byte(3'd0, 8'h11, "R4 pop first");
    rd_byte(3'd2, 8'hC0, "R3 some after pop");
    rd_byte(3'd0, 8'h22, "R5 second kept, overflow dropped");
    rd_byte(3'd2, 8'hC1, "R3 empty after pops");
    rd_byte(3'd0, 8'hFF, "R6 pop empty");
    rd_byte(3'd2, 8'hC1, "R6 still empty");
    wr_byte(3'd0, 8'h44);
    rd_byte(3'd0, 8'h44, "R6 pointers intact");
    wr_byte(3'd0, 8'h55);
    wr_byte(3'd0, 8'h66);
    rd_byte(3'd0, 8'h55, "R4 order across wrap");
    wr_byte(3'd2, 8'hC4);
    rd_byte(3'd2, 8'hC4, "R7 same mode no flush");
    rd_byte(3'd0, 8'h66, "R7 data kept");
    wr_byte(3'd0, 8'h77);
    wr_byte(3'd2, 8'h00);
    rd_byte(3'd2, 8'h01, "R7 mode change flush");
    wr_byte(3'd2, 8'hC0);
    rd_byte(3'd0, 8'hFF, "R7 flushed pop");
    wr_byte(3'd2, 8'h20);
    rd_byte(3'd0, 8'h9A, "R8 data reg kept through test mode");
    rd_byte(3'd2, 8'h21, "R1 byte mode empty");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: actual %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule